// File: doc/BRIEF.md
# GPIB Message String Framer

The framer sits between a message buffer and the command/data register port of a GPIB talker/listener controller. It turns a short text message into the exact sequence of register writes the controller needs, and it collects an incoming message under handshake holdoff. Addressing, such as untalk, unlisten and talk/listen addresses, is handled elsewhere. The framer only moves the data part of a message.

On transmit, the framer walks an external buffer from slot 0 upward. It sends each nonzero byte as a data write, and it stops at the first zero byte or after the last payload slot. It then sends a carriage return, the auxiliary command that marks the next byte with end-or-identify, and a line feed. On receive, it first enables holdoff on every data byte. It then accepts bytes from the controller one at a time. Carriage returns are dropped. A line feed ends the message. After every byte that does not end the message, a release-holdoff auxiliary command is issued. When the message ends, holdoff is released once more and then switched off. The received bytes, the message length and an overflow flag stay readable until the next receive starts.

Outgoing register writes leave on a valid/ready stream (`cmd_*`). The framer raises `cmd_valid` and holds `cmd_aux` and `cmd_byte` unchanged until a cycle in which `cmd_ready` is high, and that cycle moves the word. Incoming bytes arrive on a second valid/ready stream (`in_*`). The framer raises `in_ready` only while it waits for a byte. The source must hold `in_byte` steady while `in_valid` is high and `in_ready` is low. `tx_start`, `rx_start`, `busy`, `done` and the buffer ports are plain signals.

Top module: `gf_framer`

## Requirements
- R1: Transmit sends buffer slots 0, 1, 2 … in ascending order, each as a data word (`cmd_aux`=0). It stops before the first slot holding 0x00 or after slot 14, whichever comes first. A zero byte is never sent, and slot 15 is never sent.
- R2: After the payload, transmit issues data 0x0D, then auxiliary (`cmd_aux`=1) 0x08, then data 0x0A. It then pulses `done` for one cycle and drops `busy`.
- R3: Receive begins with auxiliary 0x83. Every accepted byte other than 0x0A is followed by exactly one auxiliary 0x02 before the next byte is accepted.
- R4: A received 0x0D is not stored and does not advance the write position.
- R5: A received 0x0A ends reception. 0x00 is written to the slot at the current write position, and `rx_len` becomes the number of bytes stored. The framer then issues auxiliary 0x02 and auxiliary 0x03 and pulses `done`.
- R6: When the 15th byte is stored without a line feed, reception ends. `rx_ovf` becomes 1 and `rx_len` becomes 15. The framer then issues auxiliary 0x02 and 0x03, and `in_ready` stays low.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_aux` and `cmd_byte` hold their values into the next cycle.
- R8: Transmit and receive never run together. A start request while `busy` is high is ignored. If both starts are high in the same idle cycle, transmit runs.
- R9: After reset, `busy`, `done`, `cmd_valid`, `in_ready`, `rx_ovf` and `rx_len` are all 0.
- R10: `rxb_byte` shows the stored slot `rxb_idx` in the same cycle. `rx_len` and `rx_ovf` clear when a receive starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Start a transmit when idle |
| rx_start | input | 1 | Start a receive when idle |
| busy | output | 1 | A transmit or receive is in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |
| txb_idx | output | 4 | Transmit buffer slot being read |
| txb_byte | input | 8 | Content of transmit slot `txb_idx` |
| cmd_valid | output | 1 | Register write word is offered |
| cmd_ready | input | 1 | Controller port takes the word |
| cmd_aux | output | 1 | 1 = auxiliary command, 0 = data byte |
| cmd_byte | output | 8 | Command code or data byte |
| in_valid | input | 1 | Received byte is offered |
| in_ready | output | 1 | Framer takes the received byte |
| in_byte | input | 8 | Received byte |
| rxb_idx | input | 4 | Receive buffer slot to read |
| rxb_byte | output | 8 | Content of receive slot `rxb_idx` |
| rx_len | output | 4 | Bytes stored by the last receive |
| rx_ovf | output | 1 | Last receive filled the buffer without a line feed |

## Verification
The assertions check, on every cycle, the rules that are local in time. They cover the stability of a stalled command word, that the two sequencers are never busy together, that no zero byte is offered as payload, that an accepted carriage return is followed by the end-or-identify command, that a dropped carriage return leaves the write position unchanged, and that a line feed is followed at once by a release. Only the bench scenarios can show whole-message behaviour. That includes the full order of register writes for early-terminated and full-length payloads, the interleaving of releases with dropped carriage returns, the stored contents and the terminating zero, the overflow ending, and the handling of start requests while busy or arriving together.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam logic [7:0] CH_CR        = 8'h0D;
  localparam logic [7:0] CH_LF        = 8'h0A;
  localparam logic [7:0] AUX_EOI_NEXT = 8'h08;
  localparam logic [7:0] AUX_HOLD_ALL = 8'h83;
  localparam logic [7:0] AUX_RELEASE  = 8'h02;
  localparam logic [7:0] AUX_HOLD_OFF = 8'h03;

  typedef struct packed {
    logic       aux;
    logic [7:0] byt;
  } cmd_t;

  typedef enum logic [2:0] {T_IDLE, T_PAY, T_CR, T_EOI, T_LF} tx_st_e;
  typedef enum logic [2:0] {R_IDLE, R_HOLD, R_WAIT, R_REL, R_REL_END, R_CLR} rx_st_e;
endpackage

// File: rtl/gf_tx_seq.sv
module gf_tx_seq
  import gf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          fin,
  output logic [IW-1:0] rd_idx,
  input  logic [7:0]    rd_byte,
  output logic          o_valid,
  input  logic          o_ready,
  output cmd_t          o_cmd
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  tx_st_e        st;
  logic [IW-1:0] idx;
  logic          pay_ok;

  assign pay_ok = (idx < LAST) && (rd_byte != 8'h00);
  assign rd_idx = idx;
  assign busy   = (st != T_IDLE);

  always_comb begin
    o_valid = 1'b0;
    o_cmd   = '0;
    case (st)
      T_PAY: begin o_valid = pay_ok; o_cmd = '{aux: 1'b0, byt: rd_byte}; end
      T_CR:  begin o_valid = 1'b1;   o_cmd = '{aux: 1'b0, byt: CH_CR}; end
      T_EOI: begin o_valid = 1'b1;   o_cmd = '{aux: 1'b1, byt: AUX_EOI_NEXT}; end
      T_LF:  begin o_valid = 1'b1;   o_cmd = '{aux: 1'b0, byt: CH_LF}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= T_IDLE;
      idx <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        T_IDLE: if (start) begin st <= T_PAY; idx <= '0; end
        T_PAY: begin
          if (!pay_ok)      st  <= T_CR;
          else if (o_ready) idx <= idx + 1'b1;
        end
        T_CR:  if (o_ready) st <= T_EOI;
        T_EOI: if (o_ready) st <= T_LF;
        T_LF:  if (o_ready) begin st <= T_IDLE; fin <= 1'b1; end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R1
  no_zero_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_cmd.aux && o_cmd.byt != CH_CR && o_cmd.byt != CH_LF) |-> (o_cmd.byt != 8'h00));

  // R2
  cr_then_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_ready && !o_cmd.aux && o_cmd.byt == CH_CR && st == T_CR)
      |=> (o_valid && o_cmd.aux && o_cmd.byt == AUX_EOI_NEXT));
endmodule

// File: rtl/gf_rx_seq.sv
module gf_rx_seq
  import gf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          fin,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_byte,
  output logic          o_valid,
  input  logic          o_ready,
  output cmd_t          o_cmd,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [IW-1:0] len,
  output logic          ovf
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  rx_st_e        st;
  logic [IW-1:0] widx;
  logic          take, is_lf, is_cr;

  assign in_ready = (st == R_WAIT);
  assign take     = in_valid && in_ready;
  assign is_lf    = (in_byte == CH_LF);
  assign is_cr    = (in_byte == CH_CR);
  assign wr_en    = take && !is_cr;
  assign wr_idx   = widx;
  assign wr_data  = is_lf ? 8'h00 : in_byte;
  assign busy     = (st != R_IDLE);

  always_comb begin
    o_valid = 1'b1;
    o_cmd   = '{aux: 1'b1, byt: AUX_RELEASE};
    case (st)
      R_HOLD:           o_cmd.byt = AUX_HOLD_ALL;
      R_REL, R_REL_END: o_cmd.byt = AUX_RELEASE;
      R_CLR:            o_cmd.byt = AUX_HOLD_OFF;
      default: begin o_valid = 1'b0; o_cmd = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= R_IDLE;
      widx <= '0;
      len  <= '0;
      ovf  <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        R_IDLE: if (start) begin
          st <= R_HOLD; widx <= '0; len <= '0; ovf <= 1'b0;
        end
        R_HOLD: if (o_ready) st <= R_WAIT;
        R_WAIT: if (take) begin
          if (is_lf) begin
            len <= widx;
            st  <= R_REL_END;
          end else if (is_cr) begin
            st <= R_REL;
          end else if (widx == LAST - 1'b1) begin
            widx <= widx + 1'b1;
            len  <= LAST;
            ovf  <= 1'b1;
            st   <= R_REL_END;
          end else begin
            widx <= widx + 1'b1;
            st   <= R_REL;
          end
        end
        R_REL:     if (o_ready) st <= R_WAIT;
        R_REL_END: if (o_ready) st <= R_CLR;
        R_CLR:     if (o_ready) begin st <= R_IDLE; fin <= 1'b1; end
        default:   st <= R_IDLE;
      endcase
    end
  end

  // R4
  cr_keeps_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_cr) |=> $stable(widx));

  // R5
  lf_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_lf) |=> (o_valid && o_cmd.aux && o_cmd.byt == AUX_RELEASE && !in_ready));

  // R3
  byte_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!in_ready && o_valid && o_cmd.byt == AUX_RELEASE));
endmodule

// File: rtl/gf_rx_store.sv
module gf_rx_store #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data
);
  logic [7:0] slots [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_en && wr_idx == IW'(i)) slots[i] <= wr_data;
    end
  end

  assign rd_data = slots[rd_idx];
endmodule

// File: rtl/gf_framer.sv
module gf_framer
  import gf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic          rx_start,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] txb_idx,
  input  logic [7:0]    txb_byte,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_aux,
  output logic [7:0]    cmd_byte,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_byte,
  input  logic [IW-1:0] rxb_idx,
  output logic [7:0]    rxb_byte,
  output logic [IW-1:0] rx_len,
  output logic          rx_ovf
);
  logic          tx_busy, rx_busy, tx_fin, rx_fin, tx_go, rx_go;
  logic          tx_v, rx_v;
  cmd_t          tx_c, rx_c, sel_c;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data;

  assign busy  = tx_busy || rx_busy;
  assign tx_go = tx_start && !busy;
  assign rx_go = rx_start && !tx_start && !busy;
  assign done  = tx_fin || rx_fin;

  gf_tx_seq #(.DEPTH(DEPTH)) u_tx (
    .clk, .rst_n, .start(tx_go), .busy(tx_busy), .fin(tx_fin),
    .rd_idx(txb_idx), .rd_byte(txb_byte),
    .o_valid(tx_v), .o_ready(cmd_ready && !rx_busy), .o_cmd(tx_c)
  );

  gf_rx_seq #(.DEPTH(DEPTH)) u_rx (
    .clk, .rst_n, .start(rx_go), .busy(rx_busy), .fin(rx_fin),
    .in_valid, .in_ready, .in_byte,
    .o_valid(rx_v), .o_ready(cmd_ready && rx_busy), .o_cmd(rx_c),
    .wr_en, .wr_idx, .wr_data, .len(rx_len), .ovf(rx_ovf)
  );

  gf_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_data, .rd_idx(rxb_idx), .rd_data(rxb_byte)
  );

  assign sel_c     = rx_busy ? rx_c : tx_c;
  assign cmd_valid = rx_busy ? rx_v : tx_v;
  assign cmd_aux   = sel_c.aux;
  assign cmd_byte  = sel_c.byt;

  // R8
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_busy && rx_busy));

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_aux) && $stable(cmd_byte)));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_gf_framer.sv
module sim_gf_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_start = 1'b0, rx_start = 1'b0;
  logic       busy, done;
  logic [3:0] txb_idx;
  logic [7:0] txb_byte;
  logic       cmd_valid, cmd_ready = 1'b0, cmd_aux;
  logic [7:0] cmd_byte;
  logic       in_valid = 1'b0, in_ready;
  logic [7:0] in_byte = 8'h00;
  logic [3:0] rxb_idx = 4'd0, rx_len;
  logic [7:0] rxb_byte;
  logic       rx_ovf;

  always #2 clk = ~clk;

  gf_framer u0 (.*);

  logic [7:0] txmem [16];
  assign txb_byte = txmem[txb_idx];

  // transmit vectors: byte i at bits [8*i+7:8*i]
  localparam logic [127:0] TXV [4] = '{
    128'h4241,
    128'h403F3E3D3C3B3A393837363534333231,
    128'h55555555555555555555555555555500,
    128'h7A003F4948
  };
  // receive vectors: byte k at bits [8*k+7:8*k]
  localparam logic [127:0] RXV [4] = '{
    128'h0A0D6261,
    128'h0A0D0D,
    128'h3F3E3D3C3B3A39383736353433323130,
    128'h0A0D4E4D4C4B4A494847464544434241
  };

  int n_chk = 0, n_fail = 0;
  logic fin_flag = 1'b0;

  // command log, filled at negedge on each handshake
  logic       log_a [512];
  logic [7:0] log_b [512];
  int         log_n = 0;
  always @(negedge clk) begin
    if (cmd_valid && cmd_ready && log_n < 512) begin
      log_a[log_n] = cmd_aux;
      log_b[log_n] = cmd_byte;
      log_n = log_n + 1;
    end
  end

  int rdy_cnt = 0;
  initial forever begin
    @(posedge clk); #1;
    cmd_ready = (rdy_cnt % 3) != 1;
    rdy_cnt++;
  end

  logic       exp_a [64];
  logic [7:0] exp_b [64];
  int         exp_n;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic a, input logic [7:0] b);
    exp_a[exp_n] = a; exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic cmp_log(input int base, input string tag);
    int got, bad;
    got = log_n - base;
    bad = -1;
    if (got == exp_n)
      for (int i = 0; i < exp_n; i++)
        if (bad < 0 && (log_a[base+i] != exp_a[i] || log_b[base+i] != exp_b[i])) bad = i;
    if (got != exp_n) chk(0, {tag, " word count"}, got, exp_n);
    else if (bad >= 0) chk(0, {tag, " word"}, {log_a[base+bad], log_b[base+bad]}, {exp_a[bad], exp_b[bad]});
    else chk(1, tag, 0, 0);
  endtask

  task automatic start_pulse(input logic t, input logic r);
    @(posedge clk); #1; tx_start = t; rx_start = r;
    @(posedge clk); #1; tx_start = 1'b0; rx_start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic rx_feed(input logic [7:0] b);
    @(posedge clk); #1; in_valid = 1'b1; in_byte = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1; in_valid = 1'b0;
  endtask

  task automatic run_tx(input int v);
    int base;
    for (int i = 0; i < 16; i++) txmem[i] = TXV[v][8*i +: 8];
    exp_n = 0;
    for (int i = 0; i < 15; i++) begin
      if (txmem[i] == 8'h00) break;
      push_exp(1'b0, txmem[i]);
    end
    push_exp(1'b0, 8'h0D); push_exp(1'b1, 8'h08); push_exp(1'b0, 8'h0A);
    base = log_n;
    start_pulse(1'b1, 1'b0);
    wait_done();
    cmp_log(base, $sformatf("R1 R2 tx vector %0d", v));
    @(negedge clk);
    chk(busy == 1'b0, "R2 busy low after tx", busy, 0);
  endtask

  task automatic run_rx(input int v);
    int base, slen;
    logic sovf, lf_end;
    logic [7:0] sb [16];
    logic [7:0] b;
    int nfeed;
    exp_n = 0; slen = 0; sovf = 1'b0; lf_end = 1'b0; nfeed = 0;
    push_exp(1'b1, 8'h83);
    for (int k = 0; k < 16; k++) begin
      b = RXV[v][8*k +: 8];
      nfeed++;
      if (b == 8'h0A) begin
        sb[slen] = 8'h00; lf_end = 1'b1;
        push_exp(1'b1, 8'h02); push_exp(1'b1, 8'h03); break;
      end else if (b == 8'h0D) begin
        push_exp(1'b1, 8'h02);
      end else begin
        sb[slen] = b; slen++;
        push_exp(1'b1, 8'h02);
        if (slen == 15) begin sovf = 1'b1; push_exp(1'b1, 8'h03); break; end
      end
    end
    base = log_n;
    start_pulse(1'b0, 1'b1);
    @(negedge clk);
    chk(rx_len == 4'd0 && rx_ovf == 1'b0, "R10 len/ovf cleared at rx start", {rx_ovf, rx_len}, 0);
    for (int k = 0; k < nfeed; k++) rx_feed(RXV[v][8*k +: 8]);
    wait_done();
    cmp_log(base, $sformatf("R3 R4 rx vector %0d", v));
    chk(rx_len == 4'(slen), $sformatf("R5 R6 rx_len vector %0d", v), rx_len, slen);
    chk(rx_ovf == sovf, $sformatf("R6 rx_ovf vector %0d", v), rx_ovf, sovf);
    chk(in_ready == 1'b0, "R6 in_ready low after end", in_ready, 0);
    for (int i = 0; i < slen + (lf_end ? 1 : 0); i++) begin
      rxb_idx = 4'(i); #1;
      chk(rxb_byte == sb[i], $sformatf("R4 R5 R10 rx slot %0d vector %0d", i, v), rxb_byte, sb[i]);
    end
  endtask

  initial begin
    int base;
    for (int i = 0; i < 16; i++) txmem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R9 busy/done after reset", {busy, done}, 0);
    chk(cmd_valid == 0 && in_ready == 0, "R9 streams idle after reset", {cmd_valid, in_ready}, 0);
    chk(rx_len == 0 && rx_ovf == 0, "R9 rx status after reset", {rx_ovf, rx_len}, 0);

    for (int v = 0; v < 4; v++) run_tx(v);
    for (int v = 0; v < 4; v++) run_rx(v);

    // R8: transmit request during a receive is ignored
    exp_n = 0;
    push_exp(1'b1, 8'h83); push_exp(1'b1, 8'h02); push_exp(1'b1, 8'h02); push_exp(1'b1, 8'h03);
    for (int i = 0; i < 16; i++) txmem[i] = 8'h33;
    base = log_n;
    start_pulse(1'b0, 1'b1);
    rx_feed(8'h78);
    start_pulse(1'b1, 1'b0);
    chk(busy == 1'b1, "R8 busy during rx", busy, 1);
    rx_feed(8'h0A);
    wait_done();
    cmp_log(base, "R8 tx start ignored while rx busy");
    chk(rx_len == 4'd1, "R8 rx_len after ignored tx", rx_len, 1);

    // R8: simultaneous starts, transmit wins and rx status is untouched
    for (int i = 0; i < 16; i++) txmem[i] = TXV[0][8*i +: 8];
    exp_n = 0;
    push_exp(1'b0, 8'h41); push_exp(1'b0, 8'h42);
    push_exp(1'b0, 8'h0D); push_exp(1'b1, 8'h08); push_exp(1'b0, 8'h0A);
    base = log_n;
    start_pulse(1'b1, 1'b1);
    @(negedge clk);
    chk(in_ready == 1'b0, "R8 rx not started with tx", in_ready, 0);
    wait_done();
    cmp_log(base, "R8 tx priority on joint start");
    chk(rx_len == 4'd1, "R8 rx_len kept after joint start", rx_len, 1);

    // R8: receive request during transmit is ignored
    base = log_n;
    start_pulse(1'b1, 1'b0);
    start_pulse(1'b0, 1'b1);
    wait_done();
    cmp_log(base, "R8 rx start ignored while tx busy");

    fin_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!fin_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule